// File: doc/BRIEF.md
# External Bus Width Sequencer

This block sits between an internal bus port and a demultiplexed external memory or peripheral whose data path is narrower than the internal word. The internal request can be 8, 16 or 32 bits wide. The external device can be 8 or 16 bits wide. When the request is wider than the device, the block turns it into a run of smaller external accesses. For each access it sets the low address bits, the four active-low byte-lane controls and the data lanes. The follow-on accesses are issued back to back and need no further internal request. When the request is no wider than the device, it goes through as one access.

For reads, every completed external access hands over one piece of data. The block places each piece into the internal word, starting with the lowest address in the least significant byte. The internal response is raised once, after the final piece arrives. The phase and wait-state generator that drives the external pins reports each finished access with a one-cycle completion pulse. It presents two captures of the external data bus: one taken on the falling edge of the output clock, and one taken on the rising edge of the input clock. A read-sample select, latched with each request, chooses between the two captures. The select is also passed on to the phase generator.

Top module: `ext_bus_assembler`

## Requirements
- R1: After a synchronous reset, no access is in progress, `ext_bc_n` is 4'b1111, `ext_start`, `rsp_valid`, `req_busy` are low and `ext_early_sel` is 0 (regular sampling).
- R2: A 16-bit request (`req_size`=1) to an 8-bit device (`dev_wide`=0) makes two external accesses, the first with address bit 0 cleared and the second with it set. The upper address bits come from the request, and the address is held during each access.
- R3: A 32-bit request (`req_size`=2 or 3) to an 8-bit device makes four accesses with address bits [1:0] equal to 00, 01, 10, 11 in that order.
- R4: A 32-bit request to a 16-bit device (`dev_wide`=1) makes two accesses with address bits [1:0] equal to 00 and then 10, each with `ext_bc_n`=4'b1100.
- R5: Every access to an 8-bit device drives `ext_bc_n`=4'b1110. A byte request (`req_size`=0) to a 16-bit device is a single access with `ext_bc_n`=4'b1110 at an even address and 4'b1101 at an odd address. A 16-bit request to a 16-bit device is a single access with 4'b1100 at the even address.
- R6: Each access begins with a one-cycle `ext_start` pulse. The next access of a run starts in the cycle right after the clock edge that samples `ext_done`.
- R7: For reads, byte k of the returned data (k counted from the request's aligned base address) lands in `rsp_rdata` bits [8k+7:8k]. Unused upper bits are zero. A byte read from a 16-bit device takes lane 0 (bits 7:0) at an even address and lane 1 (bits 15:8) at an odd one. `rsp_valid` is a single-cycle pulse in the cycle after the clock edge that samples the final `ext_done`.
- R8: For writes, each halfword access drives `ext_wdata` with the request's halfword k. Each byte access drives request byte k on both lanes of `ext_wdata`. A single-byte access to a 16-bit device drives request byte 0 on both lanes.
- R9: With `early_sample`=0 at request time, read pieces come from `ext_rdata_late`. With 1, they come from `ext_rdata_early`. `ext_early_sel` shows the latched choice from acceptance until the next request.
- R10: A request presented while `req_busy` is high is ignored: it starts no access and gives no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Internal request strobe, taken when not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | 32 | Write data, right-justified |
| dev_wide | input | 1 | 0 = 8-bit device, 1 = 16-bit device |
| early_sample | input | 1 | Read-sample select captured with the request |
| ext_done | input | 1 | One-cycle completion pulse per external access |
| ext_rdata_early | input | 16 | External data captured on the input-clock rising edge |
| ext_rdata_late | input | 16 | External data captured on the output-clock falling edge |
| req_busy | output | 1 | A request is in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Assembled read data, right-justified |
| ext_active | output | 1 | An external access run is in progress |
| ext_start | output | 1 | First cycle of each external access |
| ext_write | output | 1 | Direction of the current access |
| ext_addr | output | ADDR_W | External byte address |
| ext_bc_n | output | 4 | Active-low byte-lane controls, bit i = lane i |
| ext_wdata | output | 16 | External write data |
| ext_early_sel | output | 1 | Latched read-sample select |

## Verification
A wrong sub-access index or a wrong last-index register shows up at once: the access count, the address order or the response timing is off. These are visible on `ext_addr` and `ext_start` from the very next access, and on `rsp_valid` one cycle after the final completion. A wrong merge shows up only at the response: the byte order or the lane choice in `rsp_rdata` is wrong, so every read in the bench compares the whole word against a device model whose bytes depend on the address and on the sampling point. A stale sample select or lane pattern is visible on `ext_early_sel` and `ext_bc_n` throughout the access.

// File: rtl/ebus_asm_pkg.sv
package ebus_asm_pkg;
  localparam int LANES_INT = 4;
  localparam int LANES_EXT = 2;
  localparam int IDX_W = $clog2(LANES_INT);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WORD_ALT = 2'd3
  } xsize_e;

  localparam logic [3:0] BC_IDLE    = 4'b1111;
  localparam logic [3:0] BC_LANE0   = 4'b1110;
  localparam logic [3:0] BC_LANE1   = 4'b1101;
  localparam logic [3:0] BC_HALF_LO = 4'b1100;
endpackage

// File: rtl/ebus_asm_plan.sv
module ebus_asm_plan
  import ebus_asm_pkg::*;
(
  input  logic [1:0]       size_i,
  input  logic             wide_i,
  input  logic [1:0]       alo_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [IDX_W-1:0] last_o,
  output logic             half_o,
  output logic [1:0]       lo_o,
  output logic [3:0]       bc_o
);
  xsize_e     sz;
  logic [1:0] base;
  logic [1:0] offs;

  always_comb begin
    sz     = xsize_e'(size_i);
    half_o = wide_i && (sz != SZ_BYTE);
    case (sz)
      SZ_BYTE: base = alo_i;
      SZ_HALF: base = {alo_i[1], 1'b0};
      default: base = 2'b00;
    endcase
    if (!wide_i) begin
      case (sz)
        SZ_BYTE: last_o = IDX_W'(0);
        SZ_HALF: last_o = IDX_W'(1);
        default: last_o = IDX_W'(LANES_INT - 1);
      endcase
    end else begin
      last_o = (sz == SZ_WORD || sz == SZ_WORD_ALT) ? IDX_W'(1) : IDX_W'(0);
    end
    offs = half_o ? {idx_i[0], 1'b0} : idx_i;
    lo_o = base | offs;
    if (!wide_i)     bc_o = BC_LANE0;
    else if (half_o) bc_o = BC_HALF_LO;
    else             bc_o = lo_o[0] ? BC_LANE1 : BC_LANE0;
  end
endmodule

// File: rtl/ebus_asm_steer.sv
module ebus_asm_steer
  import ebus_asm_pkg::*;
#(
  parameter  int LANE_W = 8,
  localparam int WORD_W = LANES_INT * LANE_W,
  localparam int EXT_W  = LANES_EXT * LANE_W
) (
  input  logic [WORD_W-1:0] w_word_i,
  input  logic              w_half_i,
  input  logic [IDX_W-1:0]  w_idx_i,
  output logic [EXT_W-1:0]  w_piece_o,
  input  logic [WORD_W-1:0] r_acc_i,
  input  logic              r_half_i,
  input  logic              r_wide_i,
  input  logic              r_lo0_i,
  input  logic [IDX_W-1:0]  r_idx_i,
  input  logic              r_early_i,
  input  logic [EXT_W-1:0]  rd_early_i,
  input  logic [EXT_W-1:0]  rd_late_i,
  output logic [WORD_W-1:0] r_merged_o
);
  logic [LANES_INT-1:0][LANE_W-1:0] wb;
  logic [LANES_EXT-1:0][EXT_W-1:0]  wh;
  logic [LANES_EXT-1:0][LANE_W-1:0] rdl;
  logic [LANES_INT-1:0][LANE_W-1:0] accl;
  logic [LANES_INT-1:0][LANE_W-1:0] mrg;
  logic [LANE_W-1:0]                rbyte;

  assign wb = w_word_i;
  assign wh = w_word_i;
  assign w_piece_o = w_half_i ? wh[w_idx_i[0]] : {LANES_EXT{wb[w_idx_i]}};

  // the sampling point chosen with the request picks the capture
  assign rdl   = r_early_i ? rd_early_i : rd_late_i;
  assign rbyte = (r_wide_i && r_lo0_i) ? rdl[1] : rdl[0];
  assign accl  = r_acc_i;

  for (genvar j = 0; j < LANES_INT; j++) begin : g_lane
    localparam logic [IDX_W-1:0] JI = IDX_W'(j);
    assign mrg[j] = r_half_i ? ((JI[1] == r_idx_i[0]) ? rdl[j % LANES_EXT] : accl[j])
                             : ((JI == r_idx_i) ? rbyte : accl[j]);
  end

  assign r_merged_o = mrg;
endmodule

// File: rtl/ebus_asm_seq.sv
module ebus_asm_seq
  import ebus_asm_pkg::*;
#(
  parameter  int ADDR_W = 24,
  parameter  int LANE_W = 8,
  localparam int WORD_W = LANES_INT * LANE_W,
  localparam int EXT_W  = LANES_EXT * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic              dev_wide,
  input  logic              early_sample,
  input  logic              ext_done,
  output logic [1:0]        pl_size_o,
  output logic              pl_wide_o,
  output logic [1:0]        pl_alo_o,
  output logic [IDX_W-1:0]  pl_idx_o,
  input  logic [IDX_W-1:0]  pl_last_i,
  input  logic              pl_half_i,
  input  logic [1:0]        pl_lo_i,
  input  logic [3:0]        pl_bc_i,
  output logic [WORD_W-1:0] st_word_o,
  input  logic [EXT_W-1:0]  st_piece_i,
  output logic              st_r_half_o,
  output logic              st_r_wide_o,
  output logic              st_r_lo0_o,
  output logic [IDX_W-1:0]  st_r_idx_o,
  output logic              st_r_early_o,
  output logic [WORD_W-1:0] st_acc_o,
  input  logic [WORD_W-1:0] st_merged_i,
  output logic              req_busy,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              ext_active,
  output logic              ext_start,
  output logic              ext_write,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [3:0]        ext_bc_n,
  output logic [EXT_W-1:0]  ext_wdata,
  output logic              ext_early_sel
);
  logic              active_q, start_q, write_q, wide_q, early_q, half_q, rsp_v_q;
  logic [1:0]        size_q;
  logic [ADDR_W-1:0] addr_q, eaddr_q;
  logic [WORD_W-1:0] wdata_q, acc_q, rsp_d_q;
  logic [IDX_W-1:0]  idx_q, last_q;
  logic [3:0]        bc_q;
  logic [EXT_W-1:0]  ewd_q;

  logic              accept, done_ok, at_last, advance, finish;
  logic [ADDR_W-3:0] up;

  assign accept  = req_valid && !active_q;
  assign done_ok = active_q && ext_done;
  assign at_last = (idx_q == last_q);
  assign advance = done_ok && !at_last;
  assign finish  = done_ok && at_last;

  // plan and write steering see the values of the access about to be issued
  assign pl_size_o = accept ? req_size : size_q;
  assign pl_wide_o = accept ? dev_wide : wide_q;
  assign pl_alo_o  = accept ? req_addr[1:0] : addr_q[1:0];
  assign pl_idx_o  = accept ? '0 : idx_q + 1'b1;
  assign st_word_o = accept ? req_wdata : wdata_q;
  assign up        = accept ? req_addr[ADDR_W-1:2] : addr_q[ADDR_W-1:2];

  // read merge sees the access now in flight
  assign st_r_half_o  = half_q;
  assign st_r_wide_o  = wide_q;
  assign st_r_lo0_o   = eaddr_q[0];
  assign st_r_idx_o   = idx_q;
  assign st_r_early_o = early_q;
  assign st_acc_o     = acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      start_q  <= 1'b0;
      write_q  <= 1'b0;
      wide_q   <= 1'b0;
      early_q  <= 1'b0;
      half_q   <= 1'b0;
      rsp_v_q  <= 1'b0;
      size_q   <= '0;
      addr_q   <= '0;
      eaddr_q  <= '0;
      wdata_q  <= '0;
      acc_q    <= '0;
      rsp_d_q  <= '0;
      idx_q    <= '0;
      last_q   <= '0;
      bc_q     <= BC_IDLE;
      ewd_q    <= '0;
    end else begin
      start_q <= 1'b0;
      rsp_v_q <= 1'b0;
      if (accept) begin
        active_q <= 1'b1;
        start_q  <= 1'b1;
        write_q  <= req_write;
        wide_q   <= dev_wide;
        early_q  <= early_sample;
        size_q   <= req_size;
        addr_q   <= req_addr;
        wdata_q  <= req_wdata;
        idx_q    <= '0;
        last_q   <= pl_last_i;
        half_q   <= pl_half_i;
        acc_q    <= '0;
        eaddr_q  <= {up, pl_lo_i};
        bc_q     <= pl_bc_i;
        ewd_q    <= st_piece_i;
      end else if (advance) begin
        start_q  <= 1'b1;
        idx_q    <= pl_idx_o;
        acc_q    <= st_merged_i;
        eaddr_q  <= {up, pl_lo_i};
        bc_q     <= pl_bc_i;
        ewd_q    <= st_piece_i;
      end else if (finish) begin
        active_q <= 1'b0;
        write_q  <= 1'b0;
        bc_q     <= BC_IDLE;
        rsp_v_q  <= 1'b1;
        rsp_d_q  <= write_q ? '0 : st_merged_i;
        acc_q    <= '0;
      end
    end
  end

  assign req_busy      = active_q;
  assign rsp_valid     = rsp_v_q;
  assign rsp_rdata     = rsp_d_q;
  assign ext_active    = active_q;
  assign ext_start     = start_q;
  assign ext_write     = write_q;
  assign ext_addr      = eaddr_q;
  assign ext_bc_n      = bc_q;
  assign ext_wdata     = ewd_q;
  assign ext_early_sel = early_q;

  AST_IDLE_LANES_OFF: assert property (@(posedge clk) disable iff (rst)
    !ext_active |-> ext_bc_n == BC_IDLE); // R1
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (ext_active && !ext_done) |=> $stable(ext_addr)); // R2
  AST_LANE_COUNT: assert property (@(posedge clk) disable iff (rst)
    ext_active |-> ($countones(~ext_bc_n) == 1 || $countones(~ext_bc_n) == 2)); // R5
  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    (ext_start && !ext_done) |=> !ext_start); // R6
  AST_CHAIN_NEXT: assert property (@(posedge clk) disable iff (rst)
    (active_q && ext_done && idx_q != last_q) |=> ext_start); // R6
  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R7
  AST_RSP_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($past(ext_done) && !ext_active)); // R7
  AST_SEL_HELD: assert property (@(posedge clk) disable iff (rst)
    (ext_active && !ext_done) |=> $stable(ext_early_sel)); // R9
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (rst)
    (ext_active && !ext_done) |=> !ext_start); // R10
endmodule

// File: rtl/ext_bus_assembler.sv
module ext_bus_assembler
  import ebus_asm_pkg::*;
#(
  parameter  int ADDR_W = 24,
  parameter  int LANE_W = 8,
  localparam int WORD_W = LANES_INT * LANE_W,
  localparam int EXT_W  = LANES_EXT * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic              dev_wide,
  input  logic              early_sample,
  input  logic              ext_done,
  input  logic [EXT_W-1:0]  ext_rdata_early,
  input  logic [EXT_W-1:0]  ext_rdata_late,
  output logic              req_busy,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              ext_active,
  output logic              ext_start,
  output logic              ext_write,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [3:0]        ext_bc_n,
  output logic [EXT_W-1:0]  ext_wdata,
  output logic              ext_early_sel
);
  logic [1:0]        pl_size, pl_alo, pl_lo;
  logic              pl_wide, pl_half;
  logic [IDX_W-1:0]  pl_idx, pl_last, r_idx;
  logic [3:0]        pl_bc;
  logic [WORD_W-1:0] st_word, st_acc, st_merged;
  logic [EXT_W-1:0]  st_piece;
  logic              r_half, r_wide, r_lo0, r_early;

  ebus_asm_plan u_plan (
    .size_i(pl_size), .wide_i(pl_wide), .alo_i(pl_alo), .idx_i(pl_idx),
    .last_o(pl_last), .half_o(pl_half), .lo_o(pl_lo), .bc_o(pl_bc)
  );

  ebus_asm_steer #(.LANE_W(LANE_W)) u_steer (
    .w_word_i(st_word), .w_half_i(pl_half), .w_idx_i(pl_idx), .w_piece_o(st_piece),
    .r_acc_i(st_acc), .r_half_i(r_half), .r_wide_i(r_wide), .r_lo0_i(r_lo0),
    .r_idx_i(r_idx), .r_early_i(r_early), .rd_early_i(ext_rdata_early),
    .rd_late_i(ext_rdata_late), .r_merged_o(st_merged)
  );

  ebus_asm_seq #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .dev_wide(dev_wide), .early_sample(early_sample), .ext_done(ext_done),
    .pl_size_o(pl_size), .pl_wide_o(pl_wide), .pl_alo_o(pl_alo), .pl_idx_o(pl_idx),
    .pl_last_i(pl_last), .pl_half_i(pl_half), .pl_lo_i(pl_lo), .pl_bc_i(pl_bc),
    .st_word_o(st_word), .st_piece_i(st_piece), .st_r_half_o(r_half),
    .st_r_wide_o(r_wide), .st_r_lo0_o(r_lo0), .st_r_idx_o(r_idx),
    .st_r_early_o(r_early), .st_acc_o(st_acc), .st_merged_i(st_merged),
    .req_busy(req_busy), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ext_active(ext_active), .ext_start(ext_start), .ext_write(ext_write),
    .ext_addr(ext_addr), .ext_bc_n(ext_bc_n), .ext_wdata(ext_wdata),
    .ext_early_sel(ext_early_sel)
  );
endmodule

// File: tb/ext_bus_assembler_tb.sv
module ext_bus_assembler_tb;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0, req_write = 1'b0, dev_wide = 1'b0, early_sample = 1'b0;
  logic [1:0]    req_size = '0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          ext_done = 1'b0;
  logic [15:0]   ext_rdata_early = '0, ext_rdata_late = '0;
  logic          req_busy, rsp_valid, ext_active, ext_start, ext_write, ext_early_sel;
  logic [31:0]   rsp_rdata;
  logic [AW-1:0] ext_addr;
  logic [3:0]    ext_bc_n;
  logic [15:0]   ext_wdata;

  ext_bus_assembler #(.ADDR_W(AW)) u_dut (.*);

  always #10 clk = ~clk;

  int n_checks = 0, n_errs = 0, cyc = 0;
  bit finished = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  // device model
  int lat_cfg = 1, cnt = 0, n_starts = 0;
  logic [AW-1:0] log_addr [8];
  logic [3:0]    log_bc   [8];
  logic [15:0]   log_wd   [8];
  int            log_cyc  [8];

  function automatic logic [7:0] devb(logic [AW-1:0] a, bit early);
    return (early ? 8'hC0 : 8'h40) | {4'h0, a[3:0]};
  endfunction

  always @(negedge clk) begin
    ext_done = 1'b0;
    if (rst) cnt = 0;
    else if (ext_start) begin
      if (n_starts < 8) begin
        log_addr[n_starts] = ext_addr; log_bc[n_starts] = ext_bc_n;
        log_wd[n_starts] = ext_wdata;  log_cyc[n_starts] = cyc;
      end
      n_starts++;
      cnt = lat_cfg;
    end else if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin
        ext_done = 1'b1;
        if (dev_wide) begin
          ext_rdata_late  = {devb(ext_addr | 1, 0), devb(ext_addr & ~AW'(1), 0)};
          ext_rdata_early = {devb(ext_addr | 1, 1), devb(ext_addr & ~AW'(1), 1)};
        end else begin
          ext_rdata_late  = {8'h00, devb(ext_addr, 0)};
          ext_rdata_early = {8'h00, devb(ext_addr, 1)};
        end
      end
    end
  end

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk("R1 busy", 32'(req_busy), 0);
    chk("R1 active", 32'(ext_active), 0);
    chk("R1 start", 32'(ext_start), 0);
    chk("R1 lanes", 32'(ext_bc_n), 32'hF);
    chk("R1 rsp", 32'(rsp_valid), 0);
    chk("R1 sample sel", 32'(ext_early_sel), 0);
  endtask

  // one request, checked against the requirements; poke issues a request while busy (R10)
  task automatic xfer(string rq, bit wr, logic [1:0] sz, logic [AW-1:0] a, logic [31:0] wd,
                      bit wide, bit early, int lat, bit poke);
    int n, unit, nbytes, rcyc;
    logic [AW-1:0] base;
    logic [31:0] exp_rd, got_rd;
    logic [7:0] b;
    logic [15:0] expw;
    logic [3:0] expbc;
    bit seen;
    @(negedge clk);
    dev_wide = wide; early_sample = early; lat_cfg = lat; n_starts = 0;
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      req_valid = 1'b1; req_size = 2'd0; req_addr = a ^ AW'(24'h100); req_write = ~wr;
      @(negedge clk);
      req_valid = 1'b0;
    end
    seen = 1'b0; rcyc = 0; got_rd = '0;
    for (int t = 0; t < 200 && !seen; t++) begin
      if (rsp_valid) begin seen = 1'b1; rcyc = cyc; got_rd = rsp_rdata; end
      else @(negedge clk);
    end
    chk({rq, " response seen"}, 32'(seen), 1);
    n = wide ? (sz[1] ? 2 : 1) : (sz[1] ? 4 : (sz == 2'd1 ? 2 : 1));
    unit = (wide && sz != 2'd0) ? 2 : 1;
    nbytes = sz[1] ? 4 : (sz == 2'd1 ? 2 : 1);
    base = sz[1] ? (a & ~AW'(3)) : (sz == 2'd1 ? (a & ~AW'(1)) : a);
    chk({rq, " access count"}, 32'(n_starts), 32'(n));
    for (int k = 0; k < n && k < n_starts && k < 8; k++) begin
      chk({rq, " address"}, 32'(log_addr[k]), 32'(base + AW'(k * unit)));
      if (!wide) expbc = 4'b1110;
      else if (unit == 2) expbc = 4'b1100;
      else expbc = a[0] ? 4'b1101 : 4'b1110;
      chk("R5 lane pattern", 32'(log_bc[k]), 32'(expbc));
      if (wr) begin
        if (unit == 2) expw = wd[16*k +: 16];
        else begin b = wd[8*k +: 8]; expw = {b, b}; end
        chk("R8 write steering", 32'(log_wd[k]), 32'(expw));
      end
      if (k > 0) chk("R6 back to back", 32'(log_cyc[k]), 32'(log_cyc[k-1] + lat + 1));
    end
    if (n_starts >= n && n <= 8)
      chk("R7 response timing", 32'(rcyc), 32'(log_cyc[n-1] + lat + 1));
    if (!wr) begin
      exp_rd = '0;
      for (int i = 0; i < nbytes; i++) exp_rd[8*i +: 8] = devb(base + AW'(i), early);
      chk({rq, " R7 assembled data"}, got_rd, exp_rd);
    end
    chk("R9 latched sample select", 32'(ext_early_sel), 32'(early));
    if (poke) begin
      repeat (6) @(negedge clk);
      chk("R10 no extra access", 32'(n_starts), 32'(n));
      chk("R10 idle after", 32'(req_busy), 0);
    end
    @(negedge clk);
    chk("R7 single pulse", 32'(rsp_valid), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    test_reset();
    xfer("R2", 0, 2'd1, 24'h001236, 32'h0, 0, 0, 1, 0);
    xfer("R2", 1, 2'd1, 24'h00123A, 32'h0000BEEF, 0, 0, 2, 0);
    xfer("R3", 0, 2'd2, 24'h001234, 32'h0, 0, 0, 3, 0);
    xfer("R3", 1, 2'd3, 24'h004238, 32'hA1B2C3D4, 0, 0, 1, 0);
    xfer("R4", 0, 2'd2, 24'h00123C, 32'h0, 1, 0, 1, 0);
    xfer("R4", 1, 2'd2, 24'h005670, 32'h11223344, 1, 0, 2, 0);
    xfer("R5", 0, 2'd0, 24'h001235, 32'h0, 0, 0, 1, 0);
    xfer("R5", 0, 2'd0, 24'h001237, 32'h0, 1, 0, 1, 0);
    xfer("R5", 1, 2'd0, 24'h001238, 32'h0000005A, 1, 0, 1, 0);
    xfer("R5", 0, 2'd1, 24'h00123A, 32'h0, 1, 0, 2, 0);
    xfer("R9", 0, 2'd2, 24'h001234, 32'h0, 0, 1, 1, 0);
    xfer("R9", 0, 2'd2, 24'h001238, 32'h0, 1, 1, 2, 0);
    xfer("R9", 0, 2'd1, 24'h001232, 32'h0, 1, 0, 1, 0);
    xfer("R10", 0, 2'd2, 24'h00123C, 32'h0, 0, 0, 2, 1);
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_errs++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end
endmodule